// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block runs on the host side of a parallel NOR flash and decides when a program or erase operation in the device has ended, and how. A start request gives a polling method, the data byte that was written (only its top bit is used) and the address to poll. The engine then issues reads on a simple request/response read port. It interprets the returned status bits until it can report pass, fail or timeout.

Two methods are supported. Data polling compares bit 7 of each returned byte with bit 7 of the expected data. Toggle polling reads twice and looks for bit 6 flipping between the two reads. Bit 5 of a returned byte is the device's error flag. An error flag on its own never ends the operation as a failure. The engine first takes one or two further reads, because the operation may have finished between the read that raised the flag and the decision. A poll-round limit ends a device that never resolves.

Each result is a one-cycle `done` pulse carrying a two-bit code. A new start is taken only when the engine is idle.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, and while reset is held, `startReady` is 1, and `rdReq` and `done` are 0.
- R2: Every read request is a single-cycle `rdReq` pulse carrying the address given at the accepted start. A new request is issued only after the previous one has been answered by `rdValid`.
- R3: Data polling (`startMethod`=0): a returned byte whose bit 7 equals bit 7 of `startData` ends the operation with result 2'b00 (pass).
- R4: Data polling: a byte with bit 7 mismatched and bit 5 = 0 causes another read of the same kind.
- R5: Data polling: a byte with bit 7 mismatched and bit 5 = 1 causes exactly one more read. If that read's bit 7 matches, the result is 2'b00; otherwise it is 2'b01 (fail).
- R6: Toggle polling (`startMethod`=1): a pair of consecutive reads with equal bit 6 gives result 2'b00.
- R7: Toggle polling: if bit 6 differs within the pair and bit 5 of the second read is 0, a fresh pair of reads is taken.
- R8: Toggle polling: if bit 6 differs within the pair and bit 5 of the second read is 1, two more reads are taken. If bit 6 differs between them, the result is 2'b01; otherwise it is 2'b00.
- R9: When MAX_POLLS consecutive rounds end unresolved, the result is 2'b10 (timeout). A round is one read in data polling and one pair in toggle polling. The code 2'b11 never appears.
- R10: `done` is high for exactly one cycle per operation, with `result` valid in that cycle. `startReady` is high only while the engine is idle, which includes the `done` cycle.
- R11: A `startValid` pulse while the engine is busy is ignored. Method, address and outcome stay those of the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start request, taken when idle |
| startMethod | input | 1 | 0 = data polling, 1 = toggle polling |
| startData | input | 8 | Data written by the operation; bit 7 is the reference |
| startAddr | input | ADDR_W | Address polled |
| startReady | output | 1 | Engine idle and able to accept a start |
| rdReq | output | 1 | Read request pulse |
| rdAddr | output | ADDR_W | Read address |
| rdData | input | 8 | Returned byte (bit 7 data, bit 6 toggle, bit 5 error) |
| rdValid | input | 1 | Returned byte valid |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 pass, 01 fail, 10 timeout |

## Verification
The assertions rely on the read port answering each `rdReq` with exactly one `rdValid`, at least one cycle later, and never answering when nothing is pending. The bench's device model keeps to this. It latches each request at a falling edge and answers once after a per-vector latency of one to three cycles. It raises `rdValid` only when a countdown it started itself expires. The model produces the status bytes from a busy-read count and an error-onset index. This keeps the returned bytes in the shapes a real device gives: an inverted bit 7, a bit 6 that flips on every read, and a sticky bit 5.

// File: rtl/poll_pkg.sv
package poll_pkg;

  typedef enum logic [1:0] {
    RES_PASS    = 2'b00,
    RES_FAIL    = 2'b01,
    RES_TIMEOUT = 2'b10
  } result_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    load;       // capture start request, clear round count
    logic    issueRead;  // launch one read
    logic    savePrev;   // keep bit 6 of the returned byte
    logic    bumpCount;  // one more unresolved round
    logic    finish;     // end operation with code
    result_e code;
  } ctrl_s;

  // Conditions from datapath to control
  typedef struct packed {
    logic match7;
    logic errBit;
    logic toggled;
    logic lastRound;
    logic inFlight;
  } flags_s;

endpackage

// File: rtl/poll_datapath.sv
module poll_datapath
  import poll_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MAX_POLLS = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_s             ctrl,
  input  logic [7:0]        startData,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        rdData,
  input  logic              rdValid,
  output flags_s            flags,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              done,
  output logic [1:0]        result
);

  localparam int CNT_W = $clog2(MAX_POLLS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MAX_POLLS - 1);

  logic [ADDR_W-1:0] addrQ;
  logic              exp7Q;
  logic              prev6Q;
  logic [CNT_W-1:0]  cntQ;
  logic              inFlightQ;
  logic              rdReqQ;
  logic              doneQ;
  logic [1:0]        resultQ;

  logic unusedBits;
  assign unusedBits = ^{startData[6:0], rdData[4:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      exp7Q     <= 1'b0;
      prev6Q    <= 1'b0;
      cntQ      <= '0;
      inFlightQ <= 1'b0;
      rdReqQ    <= 1'b0;
      doneQ     <= 1'b0;
      resultQ   <= 2'b00;
    end else begin
      rdReqQ <= ctrl.issueRead;
      doneQ  <= ctrl.finish;
      if (ctrl.finish) resultQ <= ctrl.code;
      if (ctrl.load) begin
        addrQ <= startAddr;
        exp7Q <= startData[7];
        cntQ  <= '0;
      end
      if (ctrl.bumpCount) cntQ <= cntQ + CNT_W'(1);
      if (ctrl.savePrev) prev6Q <= rdData[6];
      if (ctrl.issueRead) inFlightQ <= 1'b1;
      else if (rdValid)   inFlightQ <= 1'b0;
    end
  end

  assign flags.match7    = (rdData[7] == exp7Q);
  assign flags.errBit    = rdData[5];
  assign flags.toggled   = (rdData[6] != prev6Q);
  assign flags.lastRound = (cntQ == LAST_CNT);
  assign flags.inFlight  = inFlightQ;

  assign rdReq  = rdReqQ;
  assign rdAddr = addrQ;
  assign done   = doneQ;
  assign result = resultQ;

endmodule

// File: rtl/poll_control.sv
module poll_control
  import poll_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startValid,
  input  logic   startMethod,
  input  logic   rdValid,
  input  flags_s flags,
  output ctrl_s  ctrl,
  output logic   idle
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DP_READ,   // data polling main read
    ST_DP_RECHK,  // data polling re-read after error flag
    ST_TG_FIRST,  // toggle pair, first read
    ST_TG_SECOND, // toggle pair, second read
    ST_TG_EXTRA1, // error path, first extra read
    ST_TG_EXTRA2  // error path, second extra read
  } state_e;

  state_e st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    ctrl = '0;
    nxt  = st;
    if (st == ST_IDLE) begin
      if (startValid) begin
        ctrl.load = 1'b1;
        nxt = startMethod ? ST_TG_FIRST : ST_DP_READ;
      end
    end else if (!rdValid) begin
      if (!flags.inFlight) ctrl.issueRead = 1'b1;
    end else begin
      case (st)
        ST_DP_READ: begin
          if (flags.match7) begin
            ctrl.finish = 1'b1;
            ctrl.code   = RES_PASS;
            nxt = ST_IDLE;
          end else if (flags.errBit) begin
            nxt = ST_DP_RECHK;
          end else if (flags.lastRound) begin
            ctrl.finish = 1'b1;
            ctrl.code   = RES_TIMEOUT;
            nxt = ST_IDLE;
          end else begin
            ctrl.bumpCount = 1'b1;
          end
        end
        ST_DP_RECHK: begin
          ctrl.finish = 1'b1;
          ctrl.code   = flags.match7 ? RES_PASS : RES_FAIL;
          nxt = ST_IDLE;
        end
        ST_TG_FIRST: begin
          ctrl.savePrev = 1'b1;
          nxt = ST_TG_SECOND;
        end
        ST_TG_SECOND: begin
          if (!flags.toggled) begin
            ctrl.finish = 1'b1;
            ctrl.code   = RES_PASS;
            nxt = ST_IDLE;
          end else if (flags.errBit) begin
            nxt = ST_TG_EXTRA1;
          end else if (flags.lastRound) begin
            ctrl.finish = 1'b1;
            ctrl.code   = RES_TIMEOUT;
            nxt = ST_IDLE;
          end else begin
            ctrl.bumpCount = 1'b1;
            nxt = ST_TG_FIRST;
          end
        end
        ST_TG_EXTRA1: begin
          ctrl.savePrev = 1'b1;
          nxt = ST_TG_EXTRA2;
        end
        ST_TG_EXTRA2: begin
          ctrl.finish = 1'b1;
          ctrl.code   = flags.toggled ? RES_FAIL : RES_PASS;
          nxt = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  assign idle = (st == ST_IDLE);

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import poll_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MAX_POLLS = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic              startMethod,
  input  logic [7:0]        startData,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              startReady,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  input  logic              rdValid,
  output logic              done,
  output logic [1:0]        result
);

  ctrl_s  ctrl;
  flags_s flags;

  poll_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .startMethod(startMethod),
    .rdValid    (rdValid),
    .flags      (flags),
    .ctrl       (ctrl),
    .idle       (startReady)
  );

  poll_datapath #(
    .ADDR_W   (ADDR_W),
    .MAX_POLLS(MAX_POLLS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .startData(startData),
    .startAddr(startAddr),
    .rdData   (rdData),
    .rdValid  (rdValid),
    .flags    (flags),
    .rdReq    (rdReq),
    .rdAddr   (rdAddr),
    .done     (done),
    .result   (result)
  );

endmodule

// File: rtl/poll_checker.sv
module poll_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReady,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdValid,
  input logic              done,
  input logic [1:0]        result
);

  logic pend;
  always_ff @(posedge clk) begin
    if (!rstN)        pend <= 1'b0;
    else if (rdReq)   pend <= 1'b1;
    else if (rdValid) pend <= 1'b0;
  end

  // R2
  single_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R2
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> !pend);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !startReady |=> (startReady || $stable(rdAddr)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReady |-> !rdReq);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> startReady);

  // R9
  result_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result != 2'b11));

endmodule

bind flash_done_poller poll_checker #(.ADDR_W(ADDR_W)) u_poll_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startReady(startReady),
  .rdReq     (rdReq),
  .rdAddr    (rdAddr),
  .rdValid   (rdValid),
  .done      (done),
  .result    (result)
);

// File: tb/flash_done_poller_bench.sv
module flash_done_poller_bench;

  localparam int AW    = 24;
  localparam int POLLS = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          startValid;
  logic          startMethod;
  logic [7:0]    startData;
  logic [AW-1:0] startAddr;
  logic          startReady;
  logic          rdReq;
  logic [AW-1:0] rdAddr;
  logic [7:0]    rdData;
  logic          rdValid;
  logic          done;
  logic [1:0]    result;

  always #2 clk = ~clk;

  flash_done_poller #(.ADDR_W(AW), .MAX_POLLS(POLLS)) u_flash_done_poller (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startMethod(startMethod),
    .startData(startData), .startAddr(startAddr), .startReady(startReady),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid),
    .done(done), .result(result)
  );

  int checks = 0;
  int errors = 0;

  // Device model state
  int            busyReads = 0;
  int            errAt     = 255;
  int            lat       = 1;
  int            readIdx   = 0;
  int            pendCnt   = 0;
  int            addrErrs  = 0;
  logic [7:0]    expByte   = 8'h00;
  logic [AW-1:0] curAddr   = '0;

  function automatic logic [7:0] devByte(int idx);
    logic [7:0] b;
    if (idx < busyReads)
      b = {~expByte[7], (idx % 2 == 1), (idx >= errAt), expByte[4:0]};
    else
      b = expByte;
    return b;
  endfunction

  initial begin
    rdValid = 1'b0;
    rdData  = 8'h00;
    forever begin
      @(negedge clk);
      rdValid = 1'b0;
      if (!rstN) begin
        pendCnt = 0;
      end else begin
        if (pendCnt > 0) begin
          pendCnt--;
          if (pendCnt == 0) begin
            rdValid = 1'b1;
            rdData  = devByte(readIdx);
            readIdx++;
          end
        end
        if (rdReq) begin
          pendCnt = lat;
          if (rdAddr !== curAddr) addrErrs++;
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic       method;
    logic [7:0] exp;
    logic [7:0] busy;
    logic [7:0] errAt;
    logic [1:0] lat;
    logic [1:0] res;
    logic [4:0] reads;
    logic       poke;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'hA5, 8'd0,   8'd255, 2'd1, 2'b00, 5'd1,  1'b0, 4'd3},  // R3 immediate match
    '{1'b0, 8'hA5, 8'd3,   8'd255, 2'd2, 2'b00, 5'd4,  1'b0, 4'd4},  // R4 repeats then match
    '{1'b0, 8'hA5, 8'd255, 8'd2,   2'd1, 2'b01, 5'd4,  1'b0, 4'd5},  // R5 recheck still busy: fail
    '{1'b0, 8'hA5, 8'd3,   8'd2,   2'd3, 2'b00, 5'd4,  1'b0, 4'd5},  // R5 recheck completes: pass
    '{1'b0, 8'hA5, 8'd255, 8'd255, 2'd1, 2'b10, 5'd8,  1'b0, 4'd9},  // R9 data timeout
    '{1'b0, 8'h3C, 8'd1,   8'd255, 2'd2, 2'b00, 5'd2,  1'b0, 4'd3},  // R3 reference bit 0
    '{1'b1, 8'hA5, 8'd0,   8'd255, 2'd1, 2'b00, 5'd2,  1'b0, 4'd6},  // R6 steady pair
    '{1'b1, 8'hA5, 8'd4,   8'd255, 2'd2, 2'b00, 5'd6,  1'b0, 4'd7},  // R7 two toggling pairs
    '{1'b1, 8'hA5, 8'd255, 8'd1,   2'd1, 2'b01, 5'd4,  1'b0, 4'd8},  // R8 extra reads toggle: fail
    '{1'b1, 8'hA5, 8'd2,   8'd1,   2'd3, 2'b00, 5'd4,  1'b0, 4'd8},  // R8 extra reads steady: pass
    '{1'b1, 8'hA5, 8'd255, 8'd255, 2'd1, 2'b10, 5'd16, 1'b0, 4'd9},  // R9 toggle timeout
    '{1'b0, 8'hA5, 8'd3,   8'd255, 2'd3, 2'b00, 5'd4,  1'b1, 4'd11}  // R11 start while busy
  };

  task automatic runVec(vec_t v, int idx);
    string tag;
    int    cyc;
    tag       = $sformatf("R%0d", v.req);
    busyReads = int'(v.busy);
    errAt     = int'(v.errAt);
    lat       = int'(v.lat);
    expByte   = v.exp;
    curAddr   = AW'(32'h100 + idx * 37);
    readIdx   = 0;
    addrErrs  = 0;
    @(negedge clk);
    startValid  = 1'b1;
    startMethod = v.method;
    startData   = v.exp;
    startAddr   = curAddr;
    @(negedge clk);
    startValid = 1'b0;
    // R10: not ready while busy
    chk("R10", "ready while busy", 32'(startReady), 32'd0);
    cyc = 0;
    while (cyc < 600) begin
      if (done) break;
      startValid = v.poke && (cyc == 1);
      if (startValid) begin
        startMethod = ~v.method;
        startAddr   = ~curAddr;
      end
      @(negedge clk);
      cyc++;
    end
    startValid = 1'b0;
    chk(tag, "completion", 32'(done), 32'd1);
    chk(tag, "result", 32'(result), 32'(v.res));
    chk(tag, "read count", 32'(readIdx), 32'(v.reads));
    // R2: address of every request
    chk("R2", "address mismatches", 32'(addrErrs), 32'd0);
    @(negedge clk);
    chk("R10", "done width", 32'(done), 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN        = 1'b0;
    startValid  = 1'b0;
    startMethod = 1'b0;
    startData   = 8'h00;
    startAddr   = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "ready in reset", 32'(startReady), 32'd1);
    chk("R1", "req in reset", 32'(rdReq), 32'd0);
    chk("R1", "done in reset", 32'(done), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", 32'(startReady), 32'd1);

    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // R1: reset in the middle of an unresolved operation
    busyReads = 255; errAt = 255; lat = 1; expByte = 8'hA5;
    curAddr = AW'(32'h777); readIdx = 0;
    @(negedge clk);
    startValid = 1'b1; startMethod = 1'b1; startData = 8'hA5; startAddr = curAddr;
    @(negedge clk);
    startValid = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1", "ready in mid-op reset", 32'(startReady), 32'd1);
    chk("R1", "req in mid-op reset", 32'(rdReq), 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "idle after mid-op reset", 32'(startReady), 32'd1);
    chk("R1", "no done after mid-op reset", 32'(done), 32'd0);

    // R3: engine still usable after reset
    runVec(VECS[0], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule